// File: doc/BRIEF.md
# Display Sideband Transaction Sequencer

This block carries out a single transaction on the auxiliary sideband channel of a display link on behalf of a host. The host hands over a command code, a 20-bit target address, a byte count from 1 to 16 and, for writes, up to 16 data bytes. The sequencer claims the channel, waits until the channel reports ready, and launches the transfer. It retries for as long as the far end answers DEFER, up to a fixed limit. It checks the length of any read, gives the channel back, and then reports the outcome with a one-cycle completion pulse.

The serial physical layer sits outside the block. Here it appears as a small handshake: the sequencer gives a one-cycle transfer reset strobe and then raises a go level. The channel lowers the go level by returning a completion strobe, which carries a reply code, a byte count and the read bytes. All waits are counted in clock cycles. The conversion uses a cycles-per-microsecond parameter, so the same logic serves any clock rate.

Top module: `aux_xact_seq`

## Requirements
- R1: After reset `req_ready` is 1, `own_req`, `xfer_rst`, `xfer_go` and `done_valid` are 0.
- R2: Accepting a request raises `own_req`. If `own_gnt` is low in the cycle that follows, the transaction ends with error code 1 (I/O) and no transfer reset or go is issued.
- R3: `chan_ready` is sampled at most 3 times, with POLL_US microseconds between samples. If it never reads high the result is error code 2 (busy) and no go is issued. If it reads high at a later sample the transfer proceeds normally.
- R4: Bit 0 of the command selects the direction: 1 means read, 0 means write. `xfer_wdata` is reloaded only when a write command is accepted, and a read leaves it unchanged.
- R5: While a transfer runs, `xfer_cmd` and `xfer_addr` show the accepted request, and `xfer_len` equals the byte count minus one.
- R6: Each attempt is a one-cycle `xfer_rst` followed by `xfer_go`, which is held until `xfer_done`. If `xfer_done` does not arrive within GO_TIMEOUT_US, the result is error code 2 (busy).
- R7: A reply code of 2 (DEFER) starts a new attempt. After 16 attempts that all answer DEFER, the result is error code 3 (remote).
- R8: Any other reply code ends the attempts. `done_reply` reports the last reply code sampled (0 ACK, 1 NACK), and `done_count` reports the reply byte count.
- R9: On a read, a reply byte count different from the requested count gives error code 3 (remote). A matching count returns `rep_rdata` on `done_rdata`. Outside a successful read, `done_rdata` is zero.
- R10: Every exit drops `own_req`. If `own_gnt` is still high in the cycle after the drop, the error becomes 1 (I/O). `done_valid` is a single-cycle pulse that follows SETTLE_US later, and `own_req` is low while it is high.
- R11: `req_ready` stays low from acceptance until completion, so a request presented in that time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_cmd | input | 4 | Command code, bit 0 = read |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Byte count, 1 to 16 |
| req_wdata | input | 128 | Write bytes, byte 0 in bits 7:0 |
| done_valid | output | 1 | Completion pulse |
| done_err | output | 2 | 0 none, 1 I/O, 2 busy, 3 remote |
| done_reply | output | 2 | Last reply code sampled |
| done_count | output | 5 | Last reply byte count |
| done_rdata | output | 128 | Read bytes on successful read |
| own_req | output | 1 | Channel ownership request |
| own_gnt | input | 1 | Channel ownership granted |
| chan_ready | input | 1 | Channel ready status |
| xfer_rst | output | 1 | Per-attempt transfer reset strobe |
| xfer_go | output | 1 | Transfer go, held until completion |
| xfer_cmd | output | 4 | Command for the channel |
| xfer_addr | output | 20 | Address for the channel |
| xfer_len | output | 4 | Byte count minus one |
| xfer_wdata | output | 128 | Outgoing data buffer |
| xfer_done | input | 1 | Channel cleared go, reply valid |
| rep_code | input | 2 | Reply code, 2 = DEFER |
| rep_count | input | 5 | Reply byte count |
| rep_rdata | input | 128 | Reply data bytes |

## Verification
The hardest case to reach is the retry limit, since it needs a channel that answers DEFER on every one of 16 attempts. A second hard case is the combination where the grant refuses to drop after a transaction that otherwise went well, because that I/O error must override a clean result. The bench's channel model counts transfer reset strobes and answers DEFER until a programmable attempt number is reached. Setting that number beyond the limit drives the sequencer into its give-up path. A separate knob holds the grant high to provoke the release failure, and a third releases `chan_ready` only between the second and third polls.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_IO     = 2'd1,
        ERR_BUSY   = 2'd2,
        ERR_REMOTE = 2'd3
    } aux_err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ACQ, S_POLL, S_PWAIT, S_KICK,
        S_GO, S_SETTLE, S_EVAL, S_REL, S_TAIL
    } aux_state_e;

    localparam logic [1:0] REPLY_DEFER = 2'd2;
    localparam int         TMR_W       = 32;

    function automatic logic cmd_is_read(input logic [3:0] cmd);
        return cmd[0];
    endfunction

endpackage

// File: rtl/aux_seq_timer.sv
module aux_seq_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/aux_seq_regs.sv
module aux_seq_regs #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 5,
    parameter int LEN_W  = 4,
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [3:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rep_load,
    input  logic              rd_capture,
    input  logic [1:0]        rep_code,
    input  logic [CNT_W-1:0]  rep_count,
    input  logic [DATA_W-1:0] rep_rdata,
    output logic [3:0]        xfer_cmd,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    output logic [CNT_W-1:0]  len_full,
    output logic [DATA_W-1:0] xfer_wdata,
    output logic [1:0]        done_reply,
    output logic [CNT_W-1:0]  done_count,
    output logic [DATA_W-1:0] done_rdata
);
    import aux_seq_pkg::*;

    logic [CNT_W-1:0] len_m1;
    assign len_m1 = req_len - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_cmd   <= '0;
            xfer_addr  <= '0;
            xfer_len   <= '0;
            len_full   <= '0;
            xfer_wdata <= '0;
            done_reply <= '0;
            done_count <= '0;
            done_rdata <= '0;
        end else if (accept) begin
            xfer_cmd   <= req_cmd;
            xfer_addr  <= req_addr;
            xfer_len   <= len_m1[LEN_W-1:0];
            len_full   <= req_len;
            done_reply <= '0;
            done_count <= '0;
            done_rdata <= '0;
            if (!cmd_is_read(req_cmd))
                xfer_wdata <= req_wdata;
        end else begin
            if (rep_load) begin
                done_reply <= rep_code;
                done_count <= rep_count;
            end
            if (rd_capture)
                done_rdata <= rep_rdata;
        end
    end
endmodule

// File: rtl/aux_seq_fsm.sv
module aux_seq_fsm #(
    parameter int CNT_W      = 5,
    parameter int MAX_TRIES  = 16,
    parameter int POLL_LIMIT = 3,
    parameter int POLL_CYC   = 100,
    parameter int SETTLE_CYC = 400,
    parameter int GO_CYC     = 1000
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_valid,
    input  logic                           is_read,
    input  logic [CNT_W-1:0]               len_full,
    input  logic                           own_gnt,
    input  logic                           chan_ready,
    input  logic                           xfer_done,
    input  logic [1:0]                     rep_code,
    input  logic [CNT_W-1:0]               rep_count,
    input  logic                           tmr_zero,
    output logic                           tmr_load,
    output logic [aux_seq_pkg::TMR_W-1:0]  tmr_val,
    output logic                           accept,
    output logic                           rep_load,
    output logic                           rd_capture,
    output logic                           req_ready,
    output logic                           own_req,
    output logic                           xfer_rst,
    output logic                           xfer_go,
    output logic                           done_valid,
    output aux_seq_pkg::aux_err_e          done_err
);
    import aux_seq_pkg::*;

    localparam int TRY_W  = $clog2(MAX_TRIES + 1);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);

    aux_state_e        st, st_n;
    aux_err_e          err_n;
    logic [TRY_W-1:0]  tries, tries_n;
    logic [POLL_W-1:0] polls, polls_n;
    logic              own_n, done_n;

    always_comb begin
        st_n       = st;
        err_n      = done_err;
        tries_n    = tries;
        polls_n    = polls;
        own_n      = own_req;
        done_n     = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        accept     = 1'b0;
        rep_load   = 1'b0;
        rd_capture = 1'b0;
        unique case (st)
            S_IDLE: if (req_valid) begin
                accept  = 1'b1;
                own_n   = 1'b1;
                err_n   = ERR_NONE;
                tries_n = '0;
                polls_n = '0;
                st_n    = S_ACQ;
            end
            S_ACQ: if (own_gnt) st_n = S_POLL;
                   else begin err_n = ERR_IO; own_n = 1'b0; st_n = S_REL; end
            S_POLL: if (chan_ready) st_n = S_KICK;
                else if (polls == POLL_W'(POLL_LIMIT - 1)) begin
                    err_n = ERR_BUSY; own_n = 1'b0; st_n = S_REL;
                end else begin
                    polls_n  = polls + 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(POLL_CYC);
                    st_n     = S_PWAIT;
                end
            S_PWAIT: if (tmr_zero) st_n = S_POLL;
            S_KICK: begin
                tries_n  = tries + 1'b1;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(GO_CYC);
                st_n     = S_GO;
            end
            S_GO: if (xfer_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(SETTLE_CYC);
                    st_n     = S_SETTLE;
                end else if (tmr_zero) begin
                    err_n = ERR_BUSY; own_n = 1'b0; st_n = S_REL;
                end
            S_SETTLE: if (tmr_zero) st_n = S_EVAL;
            S_EVAL: begin
                rep_load = 1'b1;
                if (rep_code == REPLY_DEFER) begin
                    if (tries == TRY_W'(MAX_TRIES)) begin
                        err_n = ERR_REMOTE; own_n = 1'b0; st_n = S_REL;
                    end else st_n = S_KICK;
                end else if (is_read && rep_count != len_full) begin
                    err_n = ERR_REMOTE; own_n = 1'b0; st_n = S_REL;
                end else begin
                    rd_capture = is_read;
                    own_n = 1'b0;
                    st_n  = S_REL;
                end
            end
            S_REL: begin
                if (own_gnt) err_n = ERR_IO;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(SETTLE_CYC);
                st_n     = S_TAIL;
            end
            S_TAIL: if (tmr_zero) begin done_n = 1'b1; st_n = S_IDLE; end
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            done_err   <= ERR_NONE;
            tries      <= '0;
            polls      <= '0;
            own_req    <= 1'b0;
            done_valid <= 1'b0;
        end else begin
            st         <= st_n;
            done_err   <= err_n;
            tries      <= tries_n;
            polls      <= polls_n;
            own_req    <= own_n;
            done_valid <= done_n;
        end
    end

    assign req_ready = (st == S_IDLE);
    assign xfer_rst  = (st == S_KICK);
    assign xfer_go   = (st == S_GO);
endmodule

// File: rtl/aux_xact_seq.sv
module aux_xact_seq #(
    parameter int ADDR_W        = 20,
    parameter int MAX_BYTES     = 16,
    parameter int MAX_TRIES     = 16,
    parameter int POLL_LIMIT    = 3,
    parameter int CYC_PER_US    = 100,
    parameter int POLL_US       = 100,
    parameter int SETTLE_US     = 400,
    parameter int GO_TIMEOUT_US = 1000,
    localparam int CNT_W  = $clog2(MAX_BYTES + 1),
    localparam int LEN_W  = $clog2(MAX_BYTES),
    localparam int DATA_W = 8 * MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done_valid,
    output logic [1:0]        done_err,
    output logic [1:0]        done_reply,
    output logic [CNT_W-1:0]  done_count,
    output logic [DATA_W-1:0] done_rdata,
    output logic              own_req,
    input  logic              own_gnt,
    input  logic              chan_ready,
    output logic              xfer_rst,
    output logic              xfer_go,
    output logic [3:0]        xfer_cmd,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    output logic [DATA_W-1:0] xfer_wdata,
    input  logic              xfer_done,
    input  logic [1:0]        rep_code,
    input  logic [CNT_W-1:0]  rep_count,
    input  logic [DATA_W-1:0] rep_rdata
);
    import aux_seq_pkg::*;

    localparam int POLL_CYC   = POLL_US * CYC_PER_US;
    localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int GO_CYC     = GO_TIMEOUT_US * CYC_PER_US;

    logic             tmr_load, tmr_zero, accept, rep_load, rd_capture;
    logic [TMR_W-1:0] tmr_val;
    logic [CNT_W-1:0] len_full;
    aux_err_e         err_q;

    aux_seq_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
    );

    aux_seq_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst(rst), .accept(accept),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .rep_load(rep_load), .rd_capture(rd_capture),
        .rep_code(rep_code), .rep_count(rep_count), .rep_rdata(rep_rdata),
        .xfer_cmd(xfer_cmd), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .len_full(len_full), .xfer_wdata(xfer_wdata),
        .done_reply(done_reply), .done_count(done_count), .done_rdata(done_rdata)
    );

    aux_seq_fsm #(
        .CNT_W(CNT_W), .MAX_TRIES(MAX_TRIES), .POLL_LIMIT(POLL_LIMIT),
        .POLL_CYC(POLL_CYC), .SETTLE_CYC(SETTLE_CYC), .GO_CYC(GO_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .is_read(cmd_is_read(xfer_cmd)), .len_full(len_full),
        .own_gnt(own_gnt), .chan_ready(chan_ready), .xfer_done(xfer_done),
        .rep_code(rep_code), .rep_count(rep_count), .tmr_zero(tmr_zero),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .accept(accept),
        .rep_load(rep_load), .rd_capture(rd_capture), .req_ready(req_ready),
        .own_req(own_req), .xfer_rst(xfer_rst), .xfer_go(xfer_go),
        .done_valid(done_valid), .done_err(err_q)
    );

    assign done_err = err_q;
endmodule

// File: rtl/aux_xact_seq_chk.sv
module aux_xact_seq_chk #(
    parameter int MAX_TRIES = 16
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic own_req,
    input logic xfer_rst,
    input logic xfer_go,
    input logic done_valid
);
    localparam int TRY_W = $clog2(MAX_TRIES + 2);
    logic [TRY_W-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst)                        seen <= '0;
        else if (req_valid && req_ready) seen <= '0;
        else if (xfer_rst)              seen <= seen + 1'b1;
    end

    // R7: attempts never exceed the retry limit
    always_comb begin
        if (!rst) a_r7_try_bound: assert (seen <= TRY_W'(MAX_TRIES));
    end

    a_r6_go_owned: assert property (@(posedge clk) disable iff (rst)
        xfer_go |-> own_req);
    a_r6_rst_then_go: assert property (@(posedge clk) disable iff (rst)
        xfer_rst |=> xfer_go);
    a_r11_busy_refuse: assert property (@(posedge clk) disable iff (rst)
        own_req |-> !req_ready);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);
    a_r10_done_released: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> !own_req);
endmodule

bind aux_xact_seq aux_xact_seq_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .own_req(own_req), .xfer_rst(xfer_rst), .xfer_go(xfer_go),
    .done_valid(done_valid)
);

// File: tb/aux_xact_seq_tb.sv
module aux_xact_seq_tb;
    localparam int POLL_US = 5, SETTLE_US = 10, GO_US = 20;

    logic clk = 0, rst = 1;
    always #2.5 clk = ~clk;

    logic         req_valid = 0, req_ready;
    logic [3:0]   req_cmd = 0;
    logic [19:0]  req_addr = 0;
    logic [4:0]   req_len = 1;
    logic [127:0] req_wdata = 0;
    logic         done_valid;
    logic [1:0]   done_err, done_reply;
    logic [4:0]   done_count;
    logic [127:0] done_rdata;
    logic         own_req, own_gnt, chan_ready;
    logic         xfer_rst, xfer_go;
    logic [3:0]   xfer_cmd;
    logic [19:0]  xfer_addr;
    logic [3:0]   xfer_len;
    logic [127:0] xfer_wdata;
    logic         xfer_done = 0;
    logic [1:0]   rep_code = 0;
    logic [4:0]   rep_count = 0;
    logic [127:0] rep_rdata = 0;

    logic gnt_en = 1, gnt_stuck = 0, rdy_en = 1, go_resp = 1;
    int   defer_n = 0, attempts = 0, dones = 0;
    logic [1:0] final_code = 0;
    int   tests = 0, fails = 0;

    assign own_gnt    = (own_req & gnt_en) | gnt_stuck;
    assign chan_ready = rdy_en;

    aux_xact_seq #(.CYC_PER_US(1), .POLL_US(POLL_US), .SETTLE_US(SETTLE_US),
                   .GO_TIMEOUT_US(GO_US)) u_dut (.*);

    typedef struct {
        logic [1:0]   err;
        logic [1:0]   rep;
        logic [4:0]   cnt;
        logic [127:0] rd;
        string        tag;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // channel model: counts attempts, answers after 3 go cycles
    initial begin
        int w = 0;
        forever begin
            @(negedge clk);
            xfer_done = 0;
            if (xfer_rst) attempts++;
            if (xfer_go && go_resp) begin
                w++;
                if (w == 3) begin
                    xfer_done = 1;
                    w = 0;
                    rep_code = (attempts <= defer_n) ? 2'd2 : final_code;
                end
            end else w = 0;
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (done_valid) begin
                exp_t e;
                e = sb.pop_front();
                chk(done_err == e.err, {e.tag, " err"}, 128'(done_err), 128'(e.err));
                chk(done_reply == e.rep, {e.tag, " reply"}, 128'(done_reply), 128'(e.rep));
                chk(done_count == e.cnt, {e.tag, " count"}, 128'(done_count), 128'(e.cnt));
                chk(done_rdata == e.rd, {e.tag, " rdata"}, done_rdata, e.rd);
                chk(!own_req, {e.tag, " R10 own released"}, 128'(own_req), 128'(0));
                dones++;
                @(negedge clk);
                chk(!done_valid, {e.tag, " R10 one-cycle done"}, 128'(done_valid), 128'(0));
            end
        end
    end

    int elapsed;
    task automatic run(input logic [3:0] cmd, input logic [19:0] addr, input logic [4:0] len,
                       input logic [127:0] wd, input logic [1:0] eerr, input logic [1:0] erep,
                       input logic [4:0] ecnt, input logic [127:0] erd, input string tag);
        exp_t e;
        int d0;
        e.err = eerr; e.rep = erep; e.cnt = ecnt; e.rd = erd; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        attempts = 0;
        d0 = dones;
        req_cmd = cmd; req_addr = addr; req_len = len; req_wdata = wd; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        elapsed = 0;
        while (dones == d0) begin @(negedge clk); elapsed++; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [127:0] wd1, rd1;
        wd1 = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
        rd1 = 128'hcafef00d_12345678_9abcdef0_55aa33cc;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !own_req && !xfer_rst && !xfer_go && !done_valid, "R1 reset",
            {req_ready, own_req, xfer_rst, xfer_go, done_valid}, 128'b10000);

        // R4 R5 write, ACK
        rep_count = 4; final_code = 0;
        fork
            run(4'h8, 20'h00202, 5'd4, wd1, 2'd0, 2'd0, 5'd4, '0, "R8 write ack");
            begin
                @(posedge xfer_go); #1;
                chk(xfer_len == 4'd3, "R5 len minus one", 128'(xfer_len), 128'd3);
                chk(xfer_addr == 20'h00202 && xfer_cmd == 4'h8, "R5 addr/cmd",
                    {xfer_cmd, xfer_addr}, {4'h8, 20'h00202});
                chk(xfer_wdata == wd1, "R4 write loads buffer", xfer_wdata, wd1);
            end
        join
        chk(attempts == 1, "R6 single attempt", 128'(attempts), 128'd1);

        // R9 read full 16 bytes, R4 buffer untouched
        rep_count = 16; rep_rdata = rd1;
        run(4'h9, 20'h00000, 5'd16, ~wd1, 2'd0, 2'd0, 5'd16, rd1, "R9 read ok");
        chk(xfer_wdata == wd1, "R4 read leaves buffer", xfer_wdata, wd1);

        // R9 short read
        rep_count = 3;
        run(4'h9, 20'h00010, 5'd4, '0, 2'd3, 2'd0, 5'd3, '0, "R9 short read");

        // R7 two DEFERs then ACK, R11 refusal mid-flight
        rep_count = 1; defer_n = 2;
        fork
            run(4'h8, 20'h00100, 5'd1, 128'h77, 2'd0, 2'd0, 5'd1, '0, "R7 defer then ack");
            begin
                repeat (6) @(negedge clk);
                req_addr = 20'hABCDE; req_valid = 1;
                @(negedge clk);
                chk(!req_ready, "R11 refused while busy", 128'(req_ready), 128'd0);
                req_valid = 0;
                @(negedge clk);
                chk(xfer_addr == 20'h00100, "R11 addr kept", 128'(xfer_addr), 128'h00100);
            end
        join
        chk(attempts == 3, "R7 three attempts", 128'(attempts), 128'd3);

        // R7 DEFER forever
        defer_n = 100;
        run(4'h8, 20'h00100, 5'd1, 128'h1, 2'd3, 2'd2, 5'd1, '0, "R7 defer limit");
        chk(attempts == 16, "R7 sixteen attempts", 128'(attempts), 128'd16);
        defer_n = 0;

        // R8 NACK
        final_code = 1;
        run(4'h8, 20'h00003, 5'd1, 128'h2, 2'd0, 2'd1, 5'd1, '0, "R8 nack");
        final_code = 0;

        // R2 no grant
        gnt_en = 0;
        run(4'h9, 20'h00004, 5'd1, '0, 2'd1, 2'd0, 5'd0, '0, "R2 no grant");
        chk(attempts == 0, "R2 no attempt", 128'(attempts), 128'd0);
        gnt_en = 1;

        // R3 never ready
        rdy_en = 0;
        run(4'h9, 20'h00005, 5'd1, '0, 2'd2, 2'd0, 5'd0, '0, "R3 not ready");
        chk(attempts == 0, "R3 no attempt", 128'(attempts), 128'd0);
        chk(elapsed >= 2 * POLL_US, "R3 poll spacing", 128'(elapsed), 128'(2 * POLL_US));

        // R3 ready at third poll
        rep_count = 1; rep_rdata = 128'h5a;
        fork
            run(4'h9, 20'h00006, 5'd1, '0, 2'd0, 2'd0, 5'd1, 128'h5a, "R3 late ready");
            begin repeat (2 * POLL_US + 3) @(negedge clk); rdy_en = 1; end
        join
        chk(attempts == 1, "R3 late ready attempt", 128'(attempts), 128'd1);

        // R6 go timeout
        go_resp = 0;
        run(4'h8, 20'h00007, 5'd1, '0, 2'd2, 2'd0, 5'd0, '0, "R6 go timeout");
        go_resp = 1;

        // R10 grant stuck after release
        gnt_stuck = 1;
        run(4'h8, 20'h00008, 5'd1, '0, 2'd1, 2'd0, 5'd1, '0, "R10 grant stuck");
        gnt_stuck = 0;

        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R10 all done seen", 128'(sb.size()), 128'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule